// File: doc/BRIEF.md
# Shared-Select Host Slave Port

This block lets an external host reach an internal register and memory space through a synchronous slave port. Several devices can share one host chip select: each one compares the host's 5-bit device-ID field with its own strapped ID and claims an access only on a match. A reserved ID value addresses every device at once, but only for writes. The host strobes one beat at a time. Each claimed beat becomes a request on a simple internal valid/ready port, and once the internal side accepts it the host sees an acknowledge pulse.

The internal port follows valid/ready rules. `m_valid` rises only for a claimed beat. While `m_ready` is low, the request and all its fields stay unchanged. The transfer completes in the cycle where both signals are high. The internal side may hold `m_ready` low for as long as it needs, and the host waits for the acknowledge during that time.

Two features extend the reach of the address pins. In window mode, only the low address pins are used, and a window base register supplies the upper internal address bits. That register is read and written at the all-ones host address, which is visible in every mode. A burst flag on the first beat makes the following beats run at consecutive internal addresses, with no host address needed. The port decodes either one strobe plus a read/write line, or separate read and write strobes. The level to which the acknowledge is released is set by configuration, so the board may use a pull-up or a pull-down.

Top module: `host_slave_port`

## Requirements
- R1: After reset, `m_valid` and `h_ack_oe` are 0, `h_rdata` is 0, and the window base register holds 0.
- R2: A beat is claimed only when `h_sel` is high, the decoded strobe is active, and `h_cid` equals `cfg_dev_id`, or `h_cid` is 31 for a write. An unclaimed beat causes no internal request and no acknowledge. Device IDs 0 to 30 are legal.
- R3: A write with `h_cid` = 31 is performed internally, but `h_ack_oe` stays 0 for the whole access. A read with `h_cid` = 31 is ignored.
- R4: With `cfg_dual_strobe` = 0, `h_ds` is the strobe and `h_rnw` = 1 selects a read. With `cfg_dual_strobe` = 1, `h_ds` alone is a read and `h_ws` alone is a write. Both strobes high together is ignored.
- R5: A claimed non-reserved beat raises `m_valid` one cycle after it is sampled. `m_valid`, `m_addr`, `m_write`, `m_be` and `m_wdata` then hold steady until the cycle where `m_ready` is high.
- R6: In the cycle after the internal handshake, `h_ack` is 1. In the next cycle, `h_ack` equals `cfg_ack_rel` and is still driven. After that, `h_ack_oe` is 0. While the request waits, `h_ack` is driven at 0.
- R7: For a read, `h_rdata` takes the `m_rdata` value present in the handshake cycle. It holds that value until the next read completes.
- R8: A write passes `h_be` to `m_be` unchanged, so any of 1, 2, 4 or 8 enabled bytes reach the internal side. A read presents all ones on `m_be`.
- R9: The all-ones host address is reserved and never produces an internal request. A write there loads the window base from `h_wdata[15:0]`. A read there returns the base zero-extended. The acknowledge comes one cycle after the beat is sampled.
- R10: With `cfg_win_en` = 0, `m_addr` is `h_addr` zero-extended. With `cfg_win_en` = 1, `m_addr` is {window base, `h_addr[11:0]`}.
- R11: A claimed non-reserved beat with `h_burst` = 1 starts a burst. The next three claimed beats go to the first beat's internal address plus 1, 2 and 3, and `h_addr` is ignored on those beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dev_id | input | 5 | Strapped device ID |
| cfg_dual_strobe | input | 1 | 1: separate read/write strobes |
| cfg_win_en | input | 1 | 1: windowed address mapping |
| cfg_ack_rel | input | 1 | Level the acknowledge is released to |
| h_sel | input | 1 | Shared chip select, active high |
| h_cid | input | 5 | Target device ID, 31 = all devices |
| h_addr | input | AW (21) | Host word address |
| h_rnw | input | 1 | Read/not-write (single-strobe mode) |
| h_ds | input | 1 | Data strobe, or read strobe in dual mode |
| h_ws | input | 1 | Write strobe (dual mode) |
| h_burst | input | 1 | Starts a burst on this beat |
| h_be | input | DW/8 (8) | Byte enables |
| h_wdata | input | DW (64) | Write data |
| h_rdata | output | DW (64) | Read data |
| h_ack | output | 1 | Transfer acknowledge value |
| h_ack_oe | output | 1 | Acknowledge drive enable |
| m_valid | output | 1 | Internal request valid |
| m_ready | input | 1 | Internal request accepted |
| m_write | output | 1 | Internal request is a write |
| m_addr | output | IAW (28) | Internal word address |
| m_be | output | DW/8 (8) | Internal byte enables |
| m_wdata | output | DW (64) | Internal write data |
| m_rdata | input | DW (64) | Internal read data, sampled at handshake |

## Verification
The bench uses the default parameters: a 21-bit host address, a 64-bit data path, a 28-bit internal address, a 12-bit window and 4-beat bursts. This puts the reserved address at 0x1FFFFF and makes the window base 16 bits wide. A windowed beat can therefore be checked against a known concatenation, and a burst runs its beat counter down to zero within four beats. The internal side withholds ready on every third cycle, so both the held-request path and the zero-wait path are exercised. Both strobe modes and both release levels are also covered.

// File: rtl/hsp_pkg.sv
package hsp_pkg;
  localparam int ID_W = 5;
  localparam logic [ID_W-1:0] BCAST_ID = '1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_ACK  = 2'd2,
    ST_REL  = 2'd3
  } hsp_state_e;
endpackage

// File: rtl/hsp_decode.sv
module hsp_decode
  import hsp_pkg::*;
(
  input  logic            cfg_dual_strobe,
  input  logic            h_sel,
  input  logic [ID_W-1:0] h_cid,
  input  logic [ID_W-1:0] cfg_dev_id,
  input  logic            h_rnw,
  input  logic            h_ds,
  input  logic            h_ws,
  output logic            claim,
  output logic            is_write,
  output logic            is_bcast
);
  logic strobe;
  logic id_match;

  always_comb begin
    if (cfg_dual_strobe) begin
      strobe   = h_ds ^ h_ws;
      is_write = h_ws;
    end else begin
      strobe   = h_ds;
      is_write = ~h_rnw;
    end
    is_bcast = (h_cid == BCAST_ID);
    id_match = (h_cid == cfg_dev_id);
    claim    = h_sel & strobe & (is_bcast ? is_write : id_match);
  end
endmodule

// File: rtl/hsp_window.sv
module hsp_window #(
  parameter int AW       = 21,
  parameter int IAW      = 28,
  parameter int WIN_BITS = 12,
  parameter int BASE_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_win_en,
  input  logic [AW-1:0]     h_addr,
  input  logic              base_we,
  input  logic [BASE_W-1:0] base_wdata,
  output logic              reserved,
  output logic [IAW-1:0]    map_addr,
  output logic [BASE_W-1:0] base_q
);
  logic [IAW-1:0] flat_addr;
  logic [IAW-1:0] win_addr;

  generate
    if (IAW > AW) begin : g_extend
      assign flat_addr = {{(IAW-AW){1'b0}}, h_addr};
    end else begin : g_direct
      assign flat_addr = h_addr[IAW-1:0];
    end
  endgenerate

  assign win_addr = {base_q, h_addr[WIN_BITS-1:0]};
  assign map_addr = cfg_win_en ? win_addr : flat_addr;
  assign reserved = &h_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_we) base_q <= base_wdata;
  end
endmodule

// File: rtl/hsp_fsm.sv
module hsp_fsm
  import hsp_pkg::*;
#(
  parameter int DW        = 64,
  parameter int IAW       = 28,
  parameter int BASE_W    = 16,
  parameter int BURST_LEN = 4,
  localparam int BW       = DW / 8,
  localparam int CNT_W    = $clog2(BURST_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              claim,
  input  logic              is_write,
  input  logic              is_bcast,
  input  logic              reserved,
  input  logic [IAW-1:0]    map_addr,
  input  logic              h_burst,
  input  logic [BW-1:0]     h_be,
  input  logic [DW-1:0]     h_wdata,
  input  logic [BASE_W-1:0] base_q,
  input  logic              cfg_ack_rel,
  input  logic              m_ready,
  input  logic [DW-1:0]     m_rdata,
  output logic              base_we,
  output logic              m_valid,
  output logic              m_write,
  output logic [IAW-1:0]    m_addr,
  output logic [BW-1:0]     m_be,
  output logic [DW-1:0]     m_wdata,
  output logic [DW-1:0]     h_rdata,
  output logic              h_ack,
  output logic              h_ack_oe
);
  hsp_state_e     state;
  logic [IAW-1:0] addr_q, next_q;
  logic [CNT_W-1:0] left_q;
  logic           wr_q, bc_q;
  logic [BW-1:0]  be_q;
  logic [DW-1:0]  wd_q, rd_q;
  logic           in_burst;
  logic           take_reserved;

  assign in_burst      = (left_q != '0);
  assign take_reserved = reserved & ~in_burst;
  assign base_we       = (state == ST_IDLE) & claim & take_reserved & is_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      addr_q <= '0;
      next_q <= '0;
      left_q <= '0;
      wr_q   <= 1'b0;
      bc_q   <= 1'b0;
      be_q   <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (claim) begin
          wr_q <= is_write;
          bc_q <= is_bcast;
          be_q <= is_write ? h_be : '1;
          wd_q <= h_wdata;
          if (in_burst) begin
            addr_q <= next_q;
            next_q <= next_q + 1'b1;
            left_q <= left_q - 1'b1;
            state  <= ST_REQ;
          end else if (reserved) begin
            if (!is_write) begin
              rd_q               <= '0;
              rd_q[BASE_W-1:0]   <= base_q;
            end
            state <= ST_ACK;
          end else begin
            addr_q <= map_addr;
            next_q <= map_addr + 1'b1;
            left_q <= h_burst ? CNT_W'(BURST_LEN - 1) : '0;
            state  <= ST_REQ;
          end
        end
        ST_REQ: if (m_ready) begin
          if (!wr_q) rd_q <= m_rdata;
          state <= ST_ACK;
        end
        ST_ACK:  state <= ST_REL;
        ST_REL:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign m_valid  = (state == ST_REQ);
  assign m_write  = wr_q;
  assign m_addr   = addr_q;
  assign m_be     = be_q;
  assign m_wdata  = wd_q;
  assign h_rdata  = rd_q;
  assign h_ack_oe = (state != ST_IDLE) & ~bc_q;
  assign h_ack    = (state == ST_ACK) |
                    ((state != ST_REQ) & (state != ST_ACK) & cfg_ack_rel);
endmodule

// File: rtl/host_slave_port.sv
module host_slave_port
  import hsp_pkg::*;
#(
  parameter int AW        = 21,
  parameter int DW        = 64,
  parameter int IAW       = 28,
  parameter int WIN_BITS  = 12,
  parameter int BURST_LEN = 4,
  localparam int BW       = DW / 8,
  localparam int BASE_W   = IAW - WIN_BITS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ID_W-1:0] cfg_dev_id,
  input  logic            cfg_dual_strobe,
  input  logic            cfg_win_en,
  input  logic            cfg_ack_rel,
  input  logic            h_sel,
  input  logic [ID_W-1:0] h_cid,
  input  logic [AW-1:0]   h_addr,
  input  logic            h_rnw,
  input  logic            h_ds,
  input  logic            h_ws,
  input  logic            h_burst,
  input  logic [BW-1:0]   h_be,
  input  logic [DW-1:0]   h_wdata,
  output logic [DW-1:0]   h_rdata,
  output logic            h_ack,
  output logic            h_ack_oe,
  output logic            m_valid,
  input  logic            m_ready,
  output logic            m_write,
  output logic [IAW-1:0]  m_addr,
  output logic [BW-1:0]   m_be,
  output logic [DW-1:0]   m_wdata,
  input  logic [DW-1:0]   m_rdata
);
  logic              claim, is_write, is_bcast;
  logic              reserved, base_we;
  logic [IAW-1:0]    map_addr;
  logic [BASE_W-1:0] base_q;

  hsp_decode u_decode (
    .cfg_dual_strobe (cfg_dual_strobe),
    .h_sel           (h_sel),
    .h_cid           (h_cid),
    .cfg_dev_id      (cfg_dev_id),
    .h_rnw           (h_rnw),
    .h_ds            (h_ds),
    .h_ws            (h_ws),
    .claim           (claim),
    .is_write        (is_write),
    .is_bcast        (is_bcast)
  );

  hsp_window #(
    .AW(AW), .IAW(IAW), .WIN_BITS(WIN_BITS), .BASE_W(BASE_W)
  ) u_window (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_win_en (cfg_win_en),
    .h_addr     (h_addr),
    .base_we    (base_we),
    .base_wdata (h_wdata[BASE_W-1:0]),
    .reserved   (reserved),
    .map_addr   (map_addr),
    .base_q     (base_q)
  );

  hsp_fsm #(
    .DW(DW), .IAW(IAW), .BASE_W(BASE_W), .BURST_LEN(BURST_LEN)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .claim       (claim),
    .is_write    (is_write),
    .is_bcast    (is_bcast),
    .reserved    (reserved),
    .map_addr    (map_addr),
    .h_burst     (h_burst),
    .h_be        (h_be),
    .h_wdata     (h_wdata),
    .base_q      (base_q),
    .cfg_ack_rel (cfg_ack_rel),
    .m_ready     (m_ready),
    .m_rdata     (m_rdata),
    .base_we     (base_we),
    .m_valid     (m_valid),
    .m_write     (m_write),
    .m_addr      (m_addr),
    .m_be        (m_be),
    .m_wdata     (m_wdata),
    .h_rdata     (h_rdata),
    .h_ack       (h_ack),
    .h_ack_oe    (h_ack_oe)
  );
endmodule

// File: rtl/hsp_checker.sv
module hsp_checker #(
  parameter int DW  = 64,
  parameter int IAW = 28,
  localparam int BW = DW / 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           h_sel,
  input logic           h_ack,
  input logic           h_ack_oe,
  input logic           cfg_ack_rel,
  input logic           m_valid,
  input logic           m_ready,
  input logic           m_write,
  input logic [IAW-1:0] m_addr,
  input logic [BW-1:0]  m_be,
  input logic [DW-1:0]  m_wdata
);
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_addr) && $stable(m_write)
                            && $stable(m_be) && $stable(m_wdata));

  p_ack_after_hs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_ready |=> h_ack && !m_valid);

  p_release_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(h_ack_oe) && !h_ack_oe |-> $past(h_ack) == $past(cfg_ack_rel));

  p_silent_is_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !h_ack_oe |-> m_write);

  p_req_needs_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_valid) |-> $past(h_sel));
endmodule

bind host_slave_port hsp_checker #(.DW(DW), .IAW(IAW)) u_checker (.*);

// File: tb/host_slave_port_test.sv
module host_slave_port_test;
  localparam int AW = 21, DW = 64, IAW = 28, BW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] cfg_dev_id = 5'd6;
  logic cfg_dual_strobe = 1'b0, cfg_win_en = 1'b0, cfg_ack_rel = 1'b0;
  logic h_sel = 1'b0, h_rnw = 1'b1, h_ds = 1'b0, h_ws = 1'b0, h_burst = 1'b0;
  logic [4:0] h_cid = 5'd0;
  logic [AW-1:0] h_addr = '0;
  logic [BW-1:0] h_be = '0;
  logic [DW-1:0] h_wdata = '0;
  logic [DW-1:0] h_rdata;
  logic h_ack, h_ack_oe, m_valid, m_write;
  logic m_ready = 1'b0;
  logic [IAW-1:0] m_addr;
  logic [BW-1:0] m_be;
  logic [DW-1:0] m_wdata;
  logic [DW-1:0] m_rdata = '0;

  always #10 clk = ~clk;

  host_slave_port uut (.*);

  int checks = 0, failures = 0;
  int cyc = 0;

  // Behavioural reference model state
  int           ms = 0;          // 0 idle, 1 request, 2 ack, 3 release
  logic [27:0]  ma = '0, mnext = '0;
  int           mleft = 0;
  bit           mw = 0, mbc = 0;
  logic [7:0]   mbe = '0;
  logic [63:0]  mwd = '0, mrd = '0;
  logic [15:0]  mbase = '0;
  logic [63:0]  mem [logic [27:0]];
  int           hs_count = 0, oe_count = 0;
  logic [27:0]  last_addr = '0;
  logic [7:0]   last_be = '0;

  function automatic logic [63:0] memval(input logic [27:0] a);
    if (mem.exists(a)) return mem[a];
    return {36'h0, a} ^ 64'h5A5A_0000_C3C3_0000;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic eq(input string req, input string what,
                    input logic [63:0] act, input logic [63:0] exp);
    check(act === exp, req, what, act, exp);
  endtask

  // Internal-side responder: withholds ready every third cycle
  always @(posedge clk) begin
    #1;
    cyc++;
    m_ready = m_valid && ((cyc % 3) != 0);
    m_rdata = memval(m_addr);
  end

  // Compare and advance the model each cycle
  always @(negedge clk) begin
    if (!rst_n) begin
      ms = 0; mleft = 0; mbase = '0; mrd = '0;
    end else begin
      bit exp_valid, exp_oe, exp_ack;
      exp_valid = (ms == 1);
      exp_oe    = (ms != 0) && !mbc;
      exp_ack   = (ms == 2) ? 1'b1 : (ms == 1) ? 1'b0 : cfg_ack_rel;
      eq("R5", "m_valid", m_valid, exp_valid);
      if (exp_valid && m_valid) begin
        eq("R10", "m_addr", m_addr, ma);
        eq("R5", "m_write", m_write, mw);
        eq("R8", "m_be", m_be, mbe);
        if (mw) eq("R5", "m_wdata", m_wdata, mwd);
      end
      eq(mbc ? "R3" : "R6", "h_ack_oe", h_ack_oe, exp_oe);
      eq("R6", "h_ack", h_ack, exp_ack);
      eq("R7", "h_rdata", h_rdata, mrd);
      if (h_ack_oe) oe_count++;

      case (ms)
        0: begin
          bit strobe, wr, bc, claim;
          if (cfg_dual_strobe) begin strobe = h_ds ^ h_ws; wr = h_ws; end
          else begin strobe = h_ds; wr = !h_rnw; end
          bc = (h_cid == 5'd31);
          claim = h_sel && strobe && (bc ? wr : (h_cid == cfg_dev_id));
          if (claim) begin
            mw = wr; mbc = bc; mbe = wr ? h_be : 8'hFF; mwd = h_wdata;
            if (mleft > 0) begin
              ma = mnext; mnext = mnext + 1; mleft--; ms = 1;
            end else if (h_addr == '1) begin
              if (wr) mbase = h_wdata[15:0];
              else mrd = {48'h0, mbase};
              ms = 2;
            end else begin
              ma = cfg_win_en ? {mbase, h_addr[11:0]} : {7'h0, h_addr};
              mnext = ma + 1;
              mleft = h_burst ? 3 : 0;
              ms = 1;
            end
          end
        end
        1: if (m_ready) begin
          if (mw) mem[ma] = mwd;
          else mrd = m_rdata;
          hs_count++; last_addr = ma; last_be = mbe;
          ms = 2;
        end
        2: ms = 3;
        default: ms = 0;
      endcase
    end
  end

  task automatic beat(input logic [4:0] cid, input logic [AW-1:0] addr,
                      input bit wr, input logic [63:0] wd, input logic [7:0] be,
                      input bit burst, input bit both);
    h_sel = 1'b1; h_cid = cid; h_addr = addr; h_wdata = wd; h_be = be;
    h_burst = burst;
    if (cfg_dual_strobe) begin
      h_ds = !wr || both; h_ws = wr || both;
    end else begin
      h_ds = 1'b1; h_rnw = !wr;
    end
    @(posedge clk); #1;
    h_sel = 1'b0; h_ds = 1'b0; h_ws = 1'b0; h_burst = 1'b0;
    while (ms != 0) begin @(posedge clk); #1; end
    @(posedge clk); #1;
  endtask

  bit done = 0;

  initial begin
    int hs0, oe0;
    repeat (3) @(posedge clk);
    #1;
    eq("R1", "m_valid in reset", m_valid, 0);
    eq("R1", "h_ack_oe in reset", h_ack_oe, 0);
    eq("R1", "h_rdata in reset", h_rdata, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R1: window base reads as zero after reset
    beat(5'd6, '1, 0, 0, 8'hFF, 0, 0);
    eq("R1", "window base after reset", h_rdata, 0);

    // R7/R8: single-strobe write then read back
    beat(5'd6, 21'h00123, 1, 64'h1122_3344_5566_7788, 8'h0F, 0, 0);
    eq("R8", "write byte enables", last_be, 8'h0F);
    beat(5'd6, 21'h00123, 0, 0, 8'h01, 0, 0);
    eq("R7", "read back", h_rdata, 64'h1122_3344_5566_7788);
    eq("R8", "read byte enables", last_be, 8'hFF);
    beat(5'd6, 21'h00124, 1, 64'hAB, 8'h01, 0, 0);
    eq("R8", "single byte enable", last_be, 8'h01);
    beat(5'd6, 21'h00125, 1, 64'hABCD, 8'h03, 0, 0);
    eq("R8", "two byte enables", last_be, 8'h03);

    // R2: a foreign ID is ignored
    hs0 = hs_count; oe0 = oe_count;
    beat(5'd3, 21'h00123, 1, 64'hDEAD, 8'hFF, 0, 0);
    eq("R2", "foreign ID handshakes", hs_count, hs0);
    eq("R2", "foreign ID ack drive", oe_count, oe0);
    beat(5'd6, 21'h00123, 0, 0, 8'hFF, 0, 0);
    eq("R2", "data untouched by foreign ID", h_rdata, 64'h1122_3344_5566_7788);

    // R3: broadcast write performed silently, broadcast read ignored
    hs0 = hs_count; oe0 = oe_count;
    beat(5'd31, 21'h00200, 1, 64'h0BCA_57, 8'hFF, 0, 0);
    eq("R3", "broadcast write handshake", hs_count, hs0 + 1);
    eq("R3", "broadcast write no ack drive", oe_count, oe0);
    hs0 = hs_count;
    beat(5'd31, 21'h00200, 0, 0, 8'hFF, 0, 0);
    eq("R3", "broadcast read ignored", hs_count, hs0);
    beat(5'd6, 21'h00200, 0, 0, 8'hFF, 0, 0);
    eq("R3", "broadcast data landed", h_rdata, 64'h0BCA_57);

    // R6: release to logic 1
    cfg_ack_rel = 1'b1;
    beat(5'd6, 21'h00123, 0, 0, 8'hFF, 0, 0);
    eq("R6", "idle level after release high", h_ack, 1);
    cfg_ack_rel = 1'b0;
    @(posedge clk); #1;

    // R4: dual-strobe decoding
    cfg_dual_strobe = 1'b1;
    beat(5'd6, 21'h00300, 1, 64'h3003, 8'hFF, 0, 0);
    beat(5'd6, 21'h00300, 0, 0, 8'hFF, 0, 0);
    eq("R4", "dual strobe write/read", h_rdata, 64'h3003);
    hs0 = hs_count;
    beat(5'd6, 21'h00300, 1, 64'h9999, 8'hFF, 0, 1);
    eq("R4", "both strobes ignored", hs_count, hs0);
    cfg_dual_strobe = 1'b0;

    // R9: reserved address loads the window base
    hs0 = hs_count;
    beat(5'd6, '1, 1, 64'hFFFF_0000_0000_00AB, 8'hFF, 0, 0);
    beat(5'd6, '1, 0, 0, 8'hFF, 0, 0);
    eq("R9", "window base read", h_rdata, 64'h00AB);
    eq("R9", "no internal request", hs_count, hs0);

    // R10: windowed mapping
    cfg_win_en = 1'b1;
    @(posedge clk); #1;
    beat(5'd6, 21'h1F0005, 1, 64'h77, 8'hFF, 0, 0);
    eq("R10", "windowed address", last_addr, 28'h00AB005);
    cfg_win_en = 1'b0;
    @(posedge clk); #1;
    beat(5'd6, 21'h1F0005, 0, 0, 8'hFF, 0, 0);
    eq("R10", "flat address", last_addr, 28'h01F0005);

    // R11: burst of four beats
    beat(5'd6, 21'h00040, 1, 64'hB0, 8'hFF, 1, 0);
    eq("R11", "burst beat 0", last_addr, 28'h40);
    for (int k = 1; k < 4; k++) begin
      beat(5'd6, 21'h15555, 1, 64'hB0 + k, 8'hFF, 0, 0);
      eq("R11", "burst beat address", last_addr, 28'h40 + k);
    end
    beat(5'd6, 21'h00050, 1, 64'hC0, 8'hFF, 0, 0);
    eq("R11", "after burst uses host address", last_addr, 28'h50);
    beat(5'd6, 21'h00042, 0, 0, 8'hFF, 0, 0);
    eq("R11", "burst data placed", h_rdata, 64'hB2);

    repeat (4) @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule